// File: doc/BRIEF.md
# Video Back-Porch Digital Clamp

This block removes the DC offset from an 8-bit sampled composite video stream so that the blanking level always lands on a fixed code chosen by the television standard. The target is 3Ch for the 525-line standard and 40h for the 625-line standard. On every line, the block looks for the horizontal sync marker. It then opens a 16-sample window a programmable number of pixels later and averages the back porch there. The average is taken over a low-pass-filtered copy of the samples, so that colour burst and chroma cancel out.

Once the window closes, the measured level becomes the new blanking estimate. From then on, every raw sample has that estimate subtracted and the standard's target code added, and the result saturates to the 8-bit range. When the clamp is switched off, samples pass through untouched. The measured level is always visible on an output for status readback. Until the first window completes, that output reads as the target code, so the stream passes with zero offset.

Top module: `bpc_top`

## Requirements
- R1: While reset is asserted, and after it until a window completes, `blank_lvl` equals the target code (3Ch when `std_pal`=0, 40h when `std_pal`=1), and `pix_out` is 00h while reset is asserted.
- R2: With `clamp_en`=0, a sample accepted with `pix_en`=1 appears unchanged on `pix_out` after the next rising clock edge.
- R3: With `clamp_en`=1, an accepted sample produces `pix_in` − `blank_lvl` + target on `pix_out` after the next rising edge. `blank_lvl` is the value present while the sample is accepted.
- R4: The clamped result saturates: a negative result gives 00h and a result above 255 gives FFh; it never wraps.
- R5: The level detector sees a 4-tap moving average of accepted samples, floor((x[n]+x[n-1]+x[n-2]+x[n-3])/4). The history is cleared to zero by reset and advances only on accepted samples.
- R6: The accepted sample with `hsync`=1 has pixel index 0 and later accepted samples count up from there. The window covers indices `win_start` to `win_start`+15. The new level is floor(sum of the 16 filtered values / 16).
- R7: The level register changes only on the accepted sample at index `win_start`+15, and holds until the next completed window, however many further samples arrive without a marker.
- R8: A marker arriving before the window completes restarts the count at index 0 and discards the partial sum; the level keeps its earlier value.
- R9: Cycles with `pix_en`=0 leave `pix_out`, `blank_lvl` and the filter history untouched, whatever `pix_in` and `hsync` carry.
- R10: The target code is taken from `std_pal` at the time each sample is accepted (0: 3Ch, 1: 40h). A stored measured level is not altered by a change of `std_pal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Sample-valid strobe; all state advances only when high |
| pix_in | input | 8 | Raw video sample |
| hsync | input | 1 | Line-start marker, qualified by `pix_en` |
| std_pal | input | 1 | Standard select: 0 for target 3Ch, 1 for target 40h |
| clamp_en | input | 1 | 1 applies the offset correction, 0 passes samples through |
| win_start | input | 8 | Pixel index after the marker where the measurement window opens |
| pix_out | output | 8 | Registered output sample |
| blank_lvl | output | 8 | Current blanking level estimate for status readback |

## Verification
The bench aims at the window's exact placement. It uses a line whose back porch begins at `win_start` behind a bright front section, so the filter's tail leaks into the first three window samples. A window shifted by one pixel, or a filter with the wrong depth, gives a level other than 42h. A marker inserted halfway through a window checks that the partial sum is thrown away; a design that kept it would report a blend of the two lines. Extreme levels drive the arithmetic past both ends of the 8-bit range, where a wrapping subtractor would output near-white for black, or the reverse. Gaps with `pix_en` low carry garbage samples and markers, so that a design that let them into the filter or the counter would drift.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    // Television standard selector as seen on the std_pal pin.
    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } tv_std_e;

    // Blanking target codes for each standard.
    localparam logic [7:0] TGT_525 = 8'h3C;
    localparam logic [7:0] TGT_625 = 8'h40;

    function automatic logic [7:0] target_code(input tv_std_e std);
        return (std == STD_625) ? TGT_625 : TGT_525;
    endfunction

endpackage

// File: rtl/bpc_lpf.sv
// Moving-average low-pass filter feeding the back-porch detector.
module bpc_lpf #(
    parameter int DW   = 8,
    parameter int TAPS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic [DW-1:0] pix_in,
    output logic [DW-1:0] filt
);
    localparam int LOG_TAPS = $clog2(TAPS);
    localparam int SUM_W    = DW + LOG_TAPS;
    localparam int HIST     = TAPS - 1;

    typedef struct packed {
        logic [HIST-1:0][DW-1:0] hist;
    } lpf_state_t;

    lpf_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(pix_in);
        for (int i = 0; i < HIST; i++) begin
            sum = sum + SUM_W'(st_q.hist[i]);
        end
        filt = sum[SUM_W-1:LOG_TAPS];

        st_d = st_q;
        if (pix_en) begin
            st_d.hist[0] = pix_in;
            for (int i = 1; i < HIST; i++) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bpc_window.sv
// Back-porch window: counts pixels after the line marker and averages
// the filtered samples inside the programmed window.
module bpc_window #(
    parameter int DW      = 8,
    parameter int WIN_LEN = 16,
    parameter int OFFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              hsync,
    input  logic [OFFS_W-1:0] win_start,
    input  logic [DW-1:0]     filt,
    output logic [DW-1:0]     meas,
    output logic              meas_valid
);
    localparam int LOG_WIN = $clog2(WIN_LEN);
    localparam int ACC_W   = DW + LOG_WIN;
    localparam int CNT_W   = $clog2((1 << OFFS_W) + WIN_LEN);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] idx;
        logic [ACC_W-1:0] acc;
        logic [DW-1:0]    lvl;
        logic             valid;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [CNT_W-1:0] first_idx;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] cur;
    logic             active;
    logic             in_win;
    logic             last;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_new;

    always_comb begin
        first_idx = CNT_W'(win_start);
        last_idx  = first_idx + CNT_W'(WIN_LEN - 1);
        cur       = hsync ? '0 : st_q.idx;
        active    = hsync | st_q.armed;
        in_win    = active && (cur >= first_idx) && (cur <= last_idx);
        last      = in_win && (cur == last_idx);
        acc_base  = hsync ? '0 : st_q.acc;
        acc_new   = in_win ? (acc_base + ACC_W'(filt)) : acc_base;

        st_d = st_q;
        if (pix_en) begin
            st_d.acc   = acc_new;
            st_d.armed = active && !last;
            if (active) begin
                st_d.idx = cur + CNT_W'(1);
            end
            if (last) begin
                st_d.lvl   = acc_new[ACC_W-1:LOG_WIN];
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas       = st_q.lvl;
    assign meas_valid = st_q.valid;

endmodule

// File: rtl/bpc_dp.sv
// Offset-correction datapath with saturation and output register.
module bpc_dp #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          clamp_en,
    input  logic [DW-1:0] pix_in,
    input  logic [DW-1:0] level,
    input  logic [DW-1:0] target,
    output logic [DW-1:0] pix_out
);
    localparam int SW = DW + 2;
    localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

    typedef struct packed {
        logic [DW-1:0] out;
    } dp_state_t;

    dp_state_t st_d, st_q;
    logic signed [SW-1:0] diff;
    logic [DW-1:0]        clamped;

    always_comb begin
        diff = $signed({2'b00, pix_in}) - $signed({2'b00, level})
             + $signed({2'b00, target});
        if (diff < 0) begin
            clamped = '0;
        end else if (diff > MAXV) begin
            clamped = '1;
        end else begin
            clamped = diff[DW-1:0];
        end

        st_d = st_q;
        if (pix_en) begin
            st_d.out = clamp_en ? clamped : pix_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out = st_q.out;

endmodule

// File: rtl/bpc_top.sv
module bpc_top #(
    parameter int DW      = 8,
    parameter int TAPS    = 4,
    parameter int WIN_LEN = 16,
    parameter int OFFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic [DW-1:0]     pix_in,
    input  logic              hsync,
    input  logic              std_pal,
    input  logic              clamp_en,
    input  logic [OFFS_W-1:0] win_start,
    output logic [DW-1:0]     pix_out,
    output logic [DW-1:0]     blank_lvl
);
    import bpc_pkg::*;

    logic [DW-1:0] filt;
    logic [DW-1:0] meas;
    logic          meas_valid;
    logic [DW-1:0] target;
    logic [DW-1:0] level;

    assign target = DW'(target_code(tv_std_e'(std_pal)));
    assign level  = meas_valid ? meas : target;

    bpc_lpf #(.DW(DW), .TAPS(TAPS)) u_lpf (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_en (pix_en),
        .pix_in (pix_in),
        .filt   (filt)
    );

    bpc_window #(.DW(DW), .WIN_LEN(WIN_LEN), .OFFS_W(OFFS_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .hsync      (hsync),
        .win_start  (win_start),
        .filt       (filt),
        .meas       (meas),
        .meas_valid (meas_valid)
    );

    bpc_dp #(.DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (pix_en),
        .clamp_en (clamp_en),
        .pix_in   (pix_in),
        .level    (level),
        .target   (target),
        .pix_out  (pix_out)
    );

    assign blank_lvl = level;

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          clamp_en,
    input logic          std_pal,
    input logic [DW-1:0] pix_in,
    input logic [DW-1:0] pix_out,
    input logic [DW-1:0] blank_lvl,
    input logic          meas_valid
);
    localparam logic [DW-1:0] T525 = DW'(8'h3C);
    localparam logic [DW-1:0] T625 = DW'(8'h40);

    assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_out));

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && meas_valid) |=> $stable(blank_lvl));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !clamp_en) |=> (pix_out == $past(pix_in)));

    assert_blank_to_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && clamp_en && pix_in == blank_lvl)
        |=> (pix_out == ($past(std_pal) ? T625 : T525)));

    assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && clamp_en && pix_in == '1 && blank_lvl <= T525)
        |=> (pix_out == '1));

    assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && clamp_en && pix_in == '0 && blank_lvl >= T625)
        |=> (pix_out == '0));

    assert_default_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> (blank_lvl == (std_pal ? T625 : T525)));

endmodule

bind bpc_top bpc_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .clamp_en   (clamp_en),
    .std_pal    (std_pal),
    .pix_in     (pix_in),
    .pix_out    (pix_out),
    .blank_lvl  (blank_lvl),
    .meas_valid (meas_valid)
);

// File: tb/bpc_top_test.sv
`timescale 1ns/1ps
module bpc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic [7:0] pix_in = 8'h00;
    logic       hsync = 1'b0;
    logic       std_pal = 1'b0;
    logic       clamp_en = 1'b0;
    logic [7:0] win_start = 8'd4;
    logic [7:0] pix_out;
    logic [7:0] blank_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int h0 = 0, h1 = 0, h2 = 0;
    int m_armed = 0, m_idx = 0, m_acc = 0, m_lvl = 0, m_valid = 0;

    always #2.5 clk = ~clk;

    bpc_top uut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
        .hsync(hsync), .std_pal(std_pal), .clamp_en(clamp_en),
        .win_start(win_start), .pix_out(pix_out), .blank_lvl(blank_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic int tgt();
        return std_pal ? 8'h40 : 8'h3C;
    endfunction

    // Drive one accepted sample, update the model, check both outputs.
    task automatic px(input int v, input bit hs, input string tag);
        int t, use_lvl, f, cur, act, inw, base, e, ws;
        t = tgt();
        ws = int'(win_start);
        use_lvl = m_valid ? m_lvl : t;
        f = (v + h0 + h1 + h2) / 4;
        cur = hs ? 0 : m_idx;
        act = (hs || m_armed) ? 1 : 0;
        inw = (act != 0 && cur >= ws && cur <= ws + 15) ? 1 : 0;
        base = hs ? 0 : m_acc;
        if (inw != 0) base += f;
        m_acc = base;
        if (inw != 0 && cur == ws + 15) begin
            m_lvl = base / 16; m_valid = 1; m_armed = 0;
        end else begin
            m_armed = act;
        end
        if (act != 0) m_idx = cur + 1;
        e = clamp_en ? (v - use_lvl + t) : v;
        if (e < 0) e = 0;
        if (e > 255) e = 255;
        h2 = h1; h1 = h0; h0 = v;
        @(negedge clk);
        pix_en = 1'b1; pix_in = 8'(v); hsync = hs;
        @(posedge clk);
        #1;
        chk({tag, " pix_out"}, int'(pix_out), e);
        chk({tag, " blank_lvl"}, int'(blank_lvl), m_valid ? m_lvl : tgt());
        pix_en = 1'b0; hsync = 1'b0;
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0; std_pal = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pix_out", int'(pix_out), 8'h00);
        chk("R1 reset level 625", int'(blank_lvl), 8'h40);
        std_pal = 1'b0;
        #1;
        chk("R1 reset level 525", int'(blank_lvl), 8'h3C);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_bypass_R2();
        clamp_en = 1'b0;
        px(8'h12, 0, "R2 bypass");
        px(8'hEE, 0, "R2 bypass");
        px(8'h00, 0, "R2 bypass");
        px(8'hFF, 0, "R2 bypass");
    endtask

    task automatic t_identity_R3();
        clamp_en = 1'b1;
        px(8'h77, 0, "R3 unmeasured identity");
        chk("R3 identity", int'(pix_out), 8'h77);
    endtask

    // Back porch alternating like burst: filter must average it out.
    task automatic t_filter_R5();
        win_start = 8'd4;
        for (int i = 0; i < 4; i++) px((i % 2) ? 8'h60 : 8'h40, 0, "R5 pre");
        for (int i = 0; i < 24; i++) px((i % 2) ? 8'h60 : 8'h40, i == 0, "R5 line");
        chk("R5 filtered level", int'(blank_lvl), 8'h50);
        px(8'h60, 0, "R3 clamp 525");
        chk("R3 clamp value", int'(pix_out), 8'h4C);
        std_pal = 1'b1;
        px(8'h60, 0, "R10 clamp 625");
        chk("R10 target 625", int'(pix_out), 8'h50);
        chk("R10 level kept", int'(blank_lvl), 8'h50);
        std_pal = 1'b0;
    endtask

    task automatic t_hold_R7();
        for (int i = 0; i < 40; i++) px(8'h90, 0, "R7 hold");
        chk("R7 level held", int'(blank_lvl), 8'h50);
    endtask

    task automatic t_offset_R6();
        win_start = 8'd20;
        for (int i = 0; i < 4; i++) px(8'hF0, 0, "R6 pre");
        for (int i = 0; i < 40; i++) px(i < 20 ? 8'hF0 : 8'h30, i == 0, "R6 line");
        chk("R6 window position", int'(blank_lvl), 8'h42);
    endtask

    task automatic t_restart_R8();
        win_start = 8'd2;
        for (int i = 0; i < 10; i++) px(8'h80, i == 0, "R8 partial");
        chk("R8 partial discarded", int'(blank_lvl), 8'h42);
        for (int i = 0; i < 30; i++) px(8'h20, i == 0, "R8 restart");
        chk("R8 restarted level", int'(blank_lvl), 8'h21);
    endtask

    task automatic t_saturate_R4();
        win_start = 8'd0;
        for (int i = 0; i < 20; i++) px(8'hA0, i == 4, "R4 high bp");
        chk("R4 level A0", int'(blank_lvl), 8'hA0);
        px(8'h10, 0, "R4 low");
        chk("R4 floor", int'(pix_out), 8'h00);
        for (int i = 0; i < 24; i++) px(8'h10, i == 4, "R4 low bp");
        chk("R4 level 10", int'(blank_lvl), 8'h10);
        px(8'hF0, 0, "R4 high");
        chk("R4 ceiling", int'(pix_out), 8'hFF);
    endtask

    task automatic t_idle_R9();
        int o, l;
        o = int'(pix_out); l = int'(blank_lvl);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pix_en = 1'b0; pix_in = 8'(8'h5A + i * 37); hsync = (i % 2) == 0;
            @(posedge clk);
            #1;
            chk("R9 idle pix_out", int'(pix_out), o);
            chk("R9 idle level", int'(blank_lvl), l);
        end
        hsync = 1'b0;
        win_start = 8'd3;
        for (int i = 0; i < 24; i++) px(8'h33 + i, i == 0, "R9 after gap");
    endtask

    initial begin
        t_reset_R1();
        t_bypass_R2();
        t_identity_R3();
        t_filter_R5();
        t_hold_R7();
        t_offset_R6();
        t_restart_R8();
        t_saturate_R4();
        t_idle_R9();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule